// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio T = 128·N + A and emits one single-cycle comparison pulse per full divide cycle. Inside, it models a dual-modulus prescaler that divides by 128 or 129, a 7-bit swallow counter and an 11-bit programmable counter. At the start of each full cycle the swallow counter holds the prescaler at 129 for A prescaler periods. The prescaler then runs at 128 until the programmable counter has counted N prescaler periods in total.

The divide values come from an external serial latch and are taken into the counters only when a full cycle ends. A change made in the middle of a cycle therefore never shortens or stretches the cycle in progress. A run control stops all counting when it is low. A single-cycle resync strobe also clears the counters. In both cases the divider restarts from a fresh load, so its output phase lines up with a reference divider that restarts at the same moment.

Top module: `swallow_divider`

## Requirements
- R1: With run_i high, resync_i low and the divide inputs held at legal values (0 ≤ A ≤ 127, 16 ≤ N ≤ 2047, A < N, including A = 0 and A = N−1), successive rising edges of pulse_o are exactly T = 128·N + A clock cycles apart.
- R2: pulse_o is high for exactly one clock cycle per full divide cycle.
- R3: In each full cycle, modulus_o (1 = divide by 129, 0 = divide by 128) is high for exactly 129·A clock cycles. It rises together with pulse_o and is never high when A = 0.
- R4: A change of div_n_i or div_a_i during a cycle leaves the length of that cycle unchanged. The new values set the length of the cycle that begins with the next pulse.
- R5: While run_i is sampled low, counting stops, and from the next clock edge pulse_o and modulus_o stay low.
- R6: After a stop, the divider restarts at the first rising edge where run_i is high and resync_i is low. It loads N and A at that edge, and pulse_o first goes high after the (T+1)-th rising edge, counting that edge as the first.
- R7: resync_i sampled high clears the divider in the same way as R5: pulse_o and modulus_o are low after that edge. The restart then follows R6.
- R8: During reset, pulse_o and modulus_o are low. After reset, the first pulse follows the restart timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_n_i | input | 11 | Latched programmable-counter value N |
| div_a_i | input | 7 | Latched swallow-counter value A |
| run_i | input | 1 | 1 = operate, 0 = power-save (counting stopped) |
| resync_i | input | 1 | Phase-reset strobe; clears the counters |
| pulse_o | output | 1 | Single-cycle pulse at the end of each full cycle |
| modulus_o | output | 1 | Prescaler modulus control, 1 = divide by 129 |

## Verification
The hardest state to reach from the ports is a divide-value change in the middle of a cycle, because the block has no visible sign of where a cycle boundary lies. The stimulus lines up on an observed pulse, waits a fixed number of cycles into the cycle, and then changes N and A. It checks that the interval in progress keeps the old length and that the following interval takes the new one. Restarts after power-save and after a resync strobe are timed from the first enabling edge, so any load cycle that is lost or added shows up as a latency error of one cycle.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned MOD_W   = 7;   // prescaler low modulus = 2**MOD_W
  localparam int unsigned SWAL_W  = 7;
  localparam int unsigned PROG_W  = 11;
  localparam int unsigned PROG_MIN = 16;

  function automatic int unsigned total_ratio(input int unsigned n, input int unsigned a);
    return (n << MOD_W) + a;
  endfunction
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int unsigned MOD_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic hi_i,
  output logic tick_o
);
  localparam int unsigned CW = MOD_W + 1;
  localparam logic [CW-1:0] LAST_LO = CW'((1 << MOD_W) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(1 << MOD_W);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = hi_i ? LAST_HI : LAST_LO;
  assign tick_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow #(
  parameter int unsigned SWAL_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [SWAL_W-1:0] val_i,
  input  logic              tick_i,
  output logic              hi_o
);
  logic [SWAL_W-1:0] cnt_q;

  assign hi_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (tick_i && hi_o) cnt_q <= cnt_q - SWAL_W'(1);
  end
endmodule

// File: rtl/swd_program.sv
module swd_program #(
  parameter int unsigned PROG_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [PROG_W-1:0] val_i,
  input  logic              tick_i,
  output logic              last_o,
  output logic              pending_o
);
  logic [PROG_W-1:0] cnt_q;

  // zero count marks "needs load" after reset or clear
  assign pending_o = (cnt_q == '0);
  assign last_o    = (cnt_q == PROG_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (tick_i)  cnt_q <= cnt_q - PROG_W'(1);
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int unsigned P_MOD_W  = MOD_W,
  parameter int unsigned P_SWAL_W = SWAL_W,
  parameter int unsigned P_PROG_W = PROG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_PROG_W-1:0] div_n_i,
  input  logic [P_SWAL_W-1:0] div_a_i,
  input  logic                run_i,
  input  logic                resync_i,
  output logic                pulse_o,
  output logic                modulus_o
);
  logic clr, pending, count_en, pre_tick, last_period, end_tick, load, sw_hi;
  logic pulse_q;

  assign clr      = !run_i || resync_i;
  assign count_en = !clr && !pending;
  assign end_tick = pre_tick && last_period;
  assign load     = !clr && (pending || end_tick);

  swd_prescaler #(.MOD_W(P_MOD_W)) i_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr || pending),
    .en_i  (count_en),
    .hi_i  (sw_hi),
    .tick_o(pre_tick)
  );

  swd_swallow #(.SWAL_W(P_SWAL_W)) i_swallow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .load_i(load),
    .val_i (div_a_i),
    .tick_i(pre_tick),
    .hi_o  (sw_hi)
  );

  swd_program #(.PROG_W(P_PROG_W)) i_program (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .load_i   (load),
    .val_i    (div_n_i),
    .tick_i   (pre_tick),
    .last_o   (last_period),
    .pending_o(pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= end_tick;
  end

  assign pulse_o   = pulse_q;
  assign modulus_o = sw_hi;
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int unsigned MOD_W = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic resync_i,
  input logic pulse_o,
  input logic modulus_o
);
  localparam int unsigned GW = 24;
  localparam logic [GW-1:0] MIN_GAP = GW'((1 << MOD_W) * 16 - 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (pulse_o)        gap_q <= '0;
    else if (gap_q != '1)    gap_q <= gap_q + GW'(1);
  end

  assert_min_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> gap_q >= MIN_GAP);

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  assert_standby_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!pulse_o && !modulus_o));

  assert_resync_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!pulse_o && !modulus_o));
endmodule

bind swallow_divider swd_checker #(.MOD_W(P_MOD_W)) i_swd_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .resync_i (resync_i),
  .pulse_o  (pulse_o),
  .modulus_o(modulus_o)
);

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  localparam int  WAIT_MAX = 20000;
  localparam int  WDOG_MAX = 190000;
  // {N, A, expected T}
  localparam int VN[NVEC] = '{16, 16, 33, 50, 100, 25};
  localparam int VA[NVEC] = '{ 0, 15, 32,  0,  99,  7};
  localparam int VT[NVEC] = '{2048, 2063, 4256, 6400, 12899, 3207};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] div_n = '0;
  logic [6:0]  div_a = '0;
  logic        run = 1'b0;
  logic        resync = 1'b0;
  logic        pulse, modulus;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  swallow_divider i_swallow_divider (
    .clk_i(clk), .rst_ni(rst_n), .div_n_i(div_n), .div_a_i(div_a),
    .run_i(run), .resync_i(resync), .pulse_o(pulse), .modulus_o(modulus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_MAX) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG_MAX);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int n, input int a);
    return 128 * n + a;
  endfunction

  // samples from now until pulse seen (inclusive)
  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < WAIT_MAX);
  endtask

  task automatic wait_pulse();
    int n;
    count_to_pulse(n);
  endtask

  // call at a pulse sample; measures interval and modulus-high samples
  task automatic measure(output int len, output int mhi);
    len = 0;
    mhi = modulus ? 1 : 0;
    forever begin
      @(negedge clk);
      len++;
      if (pulse || len >= WAIT_MAX) break;
      if (modulus) mhi++;
    end
  endtask

  initial begin
    int len, mhi, lat, quiet_p, quiet_m;

    // R8 reset state
    div_n = 11'(VN[0]); div_a = 7'(VA[0]); run = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 pulse_o in reset", int'(pulse), 0);
    chk("R8 modulus_o in reset", int'(modulus), 0);
    rst_n = 1'b1;
    count_to_pulse(lat);
    chk("R8/R6 first pulse latency after reset", lat, ratio(VN[0], VA[0]) + 1);

    // R1/R2/R3 table walk
    for (int i = 0; i < NVEC; i++) begin
      div_n = 11'(VN[i]); div_a = 7'(VA[i]);
      wait_pulse();
      @(negedge clk);
      chk("R2 pulse one cycle wide", int'(pulse), 0);
      wait_pulse();
      measure(len, mhi);
      chk("R1 pulse spacing", len, VT[i]);
      chk("R3 modulus high cycles", mhi, 129 * VA[i]);
    end

    // R4 mid-cycle change
    div_n = 11'd25; div_a = 7'd7;
    wait_pulse();
    wait_pulse();
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (len == 500) begin div_n = 11'd40; div_a = 7'd3; end
    end while (!pulse && len < WAIT_MAX);
    chk("R4 interval with mid-cycle change", len, ratio(25, 7));
    measure(len, mhi);
    chk("R4 next interval uses new values", len, ratio(40, 3));

    // R5 power-save stops output
    div_n = 11'd20; div_a = 7'd19;
    wait_pulse();
    repeat (100) @(negedge clk);
    run = 1'b0;
    quiet_p = 0; quiet_m = 0;
    repeat (3000) begin
      @(negedge clk);
      if (pulse) quiet_p++;
      if (modulus) quiet_m++;
    end
    chk("R5 no pulse in power-save", quiet_p, 0);
    chk("R5 modulus low in power-save", quiet_m, 0);
    run = 1'b1;
    count_to_pulse(lat);
    chk("R6 restart latency after power-save", lat, ratio(20, 19) + 1);
    measure(len, mhi);
    chk("R6 spacing after restart", len, ratio(20, 19));

    // R7 resync strobe mid-cycle
    repeat (777) @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    chk("R7 modulus low after resync", int'(modulus), 0);
    chk("R7 pulse low after resync", int'(pulse), 0);
    count_to_pulse(lat);
    chk("R7 restart latency after resync", lat, ratio(20, 19) + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule